// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs bus cycles on a shared, time-multiplexed address/data bus on behalf of a processor core. The core issues a byte or word request with a 20-bit byte address through a request/acknowledge port. The sequencer steps each bus cycle through a fixed order of states. In the first state it places the address on the shared pins and pulses an address-latch strobe. It then turns the bus around for reads, or drives write data, and holds a read or write strobe while the addressed device moves data. It stretches the cycle with one-clock wait states for as long as the device reports not ready.

The 16-bit data path has two byte lanes. The high-lane enable output and address bit 0 tell memory which lanes take part. A word that starts at an even address moves in one bus cycle. A word that starts at an odd address is split into two byte cycles. The core sees a single acknowledge after both cycles finish. Read data is returned right-justified for byte requests.

Top module: `mux_bus_sequencer`

## Requirements
- R1: A bus cycle moves through the states T1, T2, T3, zero or more TW, then T4, one clock each. A request seen while the block is idle starts T1 on the next clock. `req_ack` is high for one clock, during T4 of the final bus cycle of a request.
- R2: `addr_strobe` is high only during T1. During T1, `bus_oe` is high and `bus_ad_o` carries the full 20-bit address of that bus cycle.
- R3: On a read cycle, `bus_oe` is low and `rx_dir` is high from T2 through T4. `rd_n` is low in T2, T3 and every TW, and high in T4. Read data is sampled from `bus_ad_i` at the clock edge where ready is accepted.
- R4: On a write cycle, `bus_oe` is high and `bus_ad_o[15:0]` carries the lane data from T2 through T4. `wr_n` is low in T2, T3 and every TW, and high in T4. `rd_n` and `wr_n` are never low together.
- R5: `ready` is sampled at the end of T3 and at the end of each TW. Each sample that is low adds one TW clock. The first high sample leads to T4.
- R6: Lanes are encoded as the pair (address bit 0, `hi_lane_n`): even word = (0,0), even byte = (0,1), odd byte = (1,0). The low lane is bits 7:0 and the high lane is bits 15:8. A byte write drives `req_wdata[7:0]` on its own lane and zero on the other. A byte read returns the byte in `rsp_rdata[7:0]` with zero above it.
- R7: An odd-address word takes two bus cycles. The first cycle is at address A and uses the high lane for data bits 7:0. The second cycle is at A+1 modulo 2^20 and uses the low lane for data bits 15:8. There is no idle clock between the two cycles.
- R8: After reset, and whenever reset is asserted, even in the middle of a cycle, the block is idle with `addr_strobe`=0, `bus_oe`=0, `rd_n`=1, `wr_n`=1, `rx_dir`=0, `hi_lane_n`=1 and `req_ack`=0.
- R9: `ready` is ignored outside T3 and TW. A low ready during T1 or T2 adds no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte requests use bits 7:0) |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ack` on reads |
| bus_ad_o | output | 20 | Multiplexed address/data driven value |
| bus_oe | output | 1 | Drive enable for `bus_ad_o` |
| bus_ad_i | input | 16 | Data received from the shared bus |
| addr_strobe | output | 1 | Address-latch strobe (T1 only) |
| hi_lane_n | output | 1 | Active-low high byte lane enable |
| rx_dir | output | 1 | Transceiver direction: 1 = bus toward core |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ready | input | 1 | Device ready, sampled in T3/TW |

## Verification
A wrong state register shows at the strobe pins within a clock. An early or late `rd_n`/`wr_n` edge, a missing or extra TW, or `addr_strobe` outside T1 is caught in the cycle where it occurs, because every clock of every bus cycle is compared against the expected pin pattern. A wrong phase or lane selection shows in T1 of the same bus cycle as a wrong address or `hi_lane_n`. Read-capture faults show up at `req_ack` as a misplaced or stale byte in `rsp_rdata`, and the split-word cases expose each half separately.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5
   } bus_state_e;

   localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/mbs_req_hold.sv
module mbs_req_hold #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              in_write,
   input  logic              in_word,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   output logic              h_write,
   output logic              h_word,
   output logic [ADDR_W-1:0] h_addr,
   output logic [DATA_W-1:0] h_wdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_write <= 1'b0;
         h_word  <= 1'b0;
         h_addr  <= '0;
         h_wdata <= '0;
      end else if (load) begin
         h_write <= in_write;
         h_word  <= in_word;
         h_addr  <= in_addr;
         h_wdata <= in_wdata;
      end
   end
endmodule

// File: rtl/mbs_state_seq.sv
module mbs_state_seq
   import mbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       split,
   input  logic       ready,
   output bus_state_e state,
   output logic       load,
   output logic       phase_hi,
   output logic       last_cycle
);
   bus_state_e nxt;

   assign load       = req_valid && (state == ST_IDLE);
   assign last_cycle = !split || phase_hi;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req_valid) nxt = ST_T1;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ST_T3;
         ST_T3:   nxt = ready ? ST_T4 : ST_TW;
         ST_TW:   nxt = ready ? ST_T4 : ST_TW;
         ST_T4:   nxt = last_cycle ? ST_IDLE : ST_T1;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase_hi <= 1'b0;
      end else begin
         state <= nxt;
         if (load)
            phase_hi <= 1'b0;
         else if (state == ST_T4 && !last_cycle)
            phase_hi <= 1'b1;
      end
   end

   // R1: fixed ordering of the leading states
   a_r1_t1_then_t2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T1) |=> (state == ST_T2));
   a_r1_t2_then_t3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T2) |=> (state == ST_T3));
   // R5: low ready in T3/TW adds exactly one wait clock
   a_r5_wait_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_T3 || state == ST_TW) && !ready) |=> (state == ST_TW));
   a_r5_t4_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_T3 || state == ST_TW) && ready) |=> (state == ST_T4));
   // R7: split word resumes straight into T1 of its second half
   a_r7_split_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T4 && !last_cycle) |=> (state == ST_T1 && phase_hi));
endmodule

// File: rtl/mbs_lane_steer.sv
module mbs_lane_steer
   import mbs_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 16
) (
   input  logic              h_word,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              phase_hi,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic              full_word,
   output logic [DATA_W/LANE_W-1:0] lane_en,
   output logic [DATA_W-1:0] wr_lanes
);
   localparam int unsigned NUM_LANES = DATA_W / LANE_W;

   logic [LANE_W-1:0] moved_byte;

   assign full_word  = h_word && !h_addr[0];
   assign cyc_addr   = h_addr + ADDR_W'(phase_hi);
   assign moved_byte = phase_hi ? h_wdata[DATA_W-1 -: LANE_W] : h_wdata[LANE_W-1:0];

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign lane_en[g] = full_word || (cyc_addr[0] == 1'(g));
      assign wr_lanes[g*LANE_W +: LANE_W] =
         full_word  ? h_wdata[g*LANE_W +: LANE_W] :
         lane_en[g] ? moved_byte : '0;
   end

   // R6: a byte cycle enables exactly one lane
   always_comb begin
      a_r6_one_lane_for_byte: assert (full_word || $countones(lane_en) == 1);
   end
endmodule

// File: rtl/mbs_read_capture.sv
module mbs_read_capture
   import mbs_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              full_word,
   input  logic              odd_lane,
   input  logic              phase_hi,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] rdata
);
   logic [LANE_W-1:0] lane_byte;

   assign lane_byte = odd_lane ? bus_i[DATA_W-1 -: LANE_W] : bus_i[LANE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         if (full_word)
            rdata <= bus_i;
         else if (phase_hi)
            rdata[DATA_W-1 -: LANE_W] <= lane_byte;
         else
            rdata <= {{(DATA_W-LANE_W){1'b0}}, lane_byte};
      end
   end

   // R7: the second half of a split word leaves the first byte intact
   a_r7_keep_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && phase_hi && !full_word) |=> (rdata[LANE_W-1:0] == $past(rdata[LANE_W-1:0])));
endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
   import mbs_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_ad_o,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_ad_i,
   output logic              addr_strobe,
   output logic              hi_lane_n,
   output logic              rx_dir,
   output logic              rd_n,
   output logic              wr_n,
   input  logic              ready
);
   localparam int unsigned NUM_LANES = DATA_W / LANE_W;
   localparam int unsigned PAD_W     = ADDR_W - DATA_W;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("mux_bus_sequencer: DATA_W must be 16 (two byte lanes)");
   end
   if (ADDR_W <= DATA_W) begin : g_bad_addr_w
      $error("mux_bus_sequencer: ADDR_W must exceed DATA_W");
   end

   bus_state_e               state;
   logic                     load, phase_hi, last_cycle;
   logic                     h_write, h_word;
   logic [ADDR_W-1:0]        h_addr, cyc_addr;
   logic [DATA_W-1:0]        h_wdata, wr_lanes;
   logic                     full_word;
   logic [NUM_LANES-1:0]     lane_en;
   logic                     data_phase, strobe_phase, capture;

   mbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(load),
      .in_write(req_write), .in_word(req_word), .in_addr(req_addr), .in_wdata(req_wdata),
      .h_write(h_write), .h_word(h_word), .h_addr(h_addr), .h_wdata(h_wdata)
   );

   mbs_state_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .split(h_word && h_addr[0]), .ready(ready),
      .state(state), .load(load), .phase_hi(phase_hi), .last_cycle(last_cycle)
   );

   mbs_lane_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
      .h_word(h_word), .h_addr(h_addr), .h_wdata(h_wdata), .phase_hi(phase_hi),
      .cyc_addr(cyc_addr), .full_word(full_word), .lane_en(lane_en), .wr_lanes(wr_lanes)
   );

   assign strobe_phase = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
   assign data_phase   = strobe_phase || (state == ST_T4);
   assign capture      = (state == ST_T3 || state == ST_TW) && ready && !h_write;

   mbs_read_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .capture(capture), .full_word(full_word),
      .odd_lane(cyc_addr[0]), .phase_hi(phase_hi), .bus_i(bus_ad_i), .rdata(rsp_rdata)
   );

   assign addr_strobe = (state == ST_T1);
   assign bus_oe      = (state == ST_T1) || (data_phase && h_write);
   assign rx_dir      = data_phase && !h_write;
   assign rd_n        = !(strobe_phase && !h_write);
   assign wr_n        = !(strobe_phase && h_write);
   assign hi_lane_n   = (state == ST_IDLE) ? 1'b1 : !lane_en[NUM_LANES-1];
   assign req_ack     = (state == ST_T4) && last_cycle;

   always_comb begin
      if (state == ST_T1)
         bus_ad_o = cyc_addr;
      else if (data_phase && h_write)
         bus_ad_o = {{PAD_W{1'b0}}, wr_lanes};
      else
         bus_ad_o = '0;
   end

   // R2: the latch strobe is a single-clock pulse
   a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |=> !addr_strobe);
   // R3: pins are never driven while the bus faces the core
   a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dir |-> !bus_oe);
   // R4: read and write strobes are exclusive
   a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   // R1: completion is a one-clock pulse
   a_r1_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   // R2: the address strobe follows an idle clock or a finished first half
   a_r2_strobe_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_strobe) |-> ($past(state) == ST_IDLE || $past(state) == ST_T4));
endmodule

// File: tb/tb_mux_bus_sequencer.sv
module tb_mux_bus_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ack;
   logic [15:0] rsp_rdata;
   logic [19:0] bus_ad_o;
   logic        bus_oe;
   logic [15:0] bus_ad_i = '0;
   logic        addr_strobe, hi_lane_n, rx_dir, rd_n, wr_n;
   logic        ready = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   mux_bus_sequencer dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ack(req_ack), .rsp_rdata(rsp_rdata), .bus_ad_o(bus_ad_o), .bus_oe(bus_oe),
      .bus_ad_i(bus_ad_i), .addr_strobe(addr_strobe), .hi_lane_n(hi_lane_n),
      .rx_dir(rx_dir), .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
   );

   typedef struct packed {
      logic        wr;
      logic        wd;
      logic [19:0] addr;
      logic [15:0] wdata;
      logic [15:0] bus0;
      logic [15:0] bus1;
      logic [3:0]  waits;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 20'h12344, 16'h0000, 16'hA1B2, 16'h0000, 4'd0},
      '{1'b0, 1'b1, 20'h00010, 16'h0000, 16'h5566, 16'h0000, 4'd2},
      '{1'b0, 1'b0, 20'h0ABC5, 16'h0000, 16'hC3D4, 16'h0000, 4'd1},
      '{1'b0, 1'b0, 20'h0ABC4, 16'h0000, 16'hC3D4, 16'h0000, 4'd0},
      '{1'b0, 1'b1, 20'h34567, 16'h0000, 16'hEE11, 16'h77FF, 4'd1},
      '{1'b1, 1'b1, 20'h20000, 16'hBEEF, 16'h0000, 16'h0000, 4'd0},
      '{1'b1, 1'b0, 20'h20001, 16'h0042, 16'h0000, 16'h0000, 4'd3},
      '{1'b1, 1'b0, 20'h20002, 16'h00A5, 16'h0000, 16'h0000, 4'd0},
      '{1'b1, 1'b1, 20'h3FFF1, 16'h1234, 16'h0000, 16'h0000, 4'd2},
      '{1'b0, 1'b1, 20'hFFFFF, 16'h0000, 16'h9A00, 16'h00BC, 4'd0}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // R6/R7: expected read result from the lane rules
   function automatic logic [15:0] exp_read(vec_t v);
      if (v.wd && !v.addr[0]) return v.bus0;
      if (!v.wd) return v.addr[0] ? {8'h00, v.bus0[15:8]} : {8'h00, v.bus0[7:0]};
      return {v.bus1[7:0], v.bus0[15:8]};
   endfunction

   function automatic logic [15:0] exp_lanes(vec_t v, bit ph);
      logic [7:0] b;
      logic [19:0] a;
      if (v.wd && !v.addr[0]) return v.wdata;
      b = ph ? v.wdata[15:8] : v.wdata[7:0];
      a = v.addr + 20'(ph);
      return a[0] ? {b, 8'h00} : {8'h00, b};
   endfunction

   task automatic check_idle(input string tag);
      chk(addr_strobe == 1'b0, tag, "addr_strobe idle", 32'(addr_strobe), 0);
      chk(bus_oe == 1'b0,      tag, "bus_oe idle", 32'(bus_oe), 0);
      chk(rd_n == 1'b1 && wr_n == 1'b1, tag, "strobes idle", {rd_n, wr_n}, 3);
      chk(rx_dir == 1'b0 && hi_lane_n == 1'b1, tag, "dir/lane idle", {rx_dir, hi_lane_n}, 1);
      chk(req_ack == 1'b0,     tag, "req_ack idle", 32'(req_ack), 0);
   endtask

   task automatic run_txn(input vec_t v);
      int ncyc;
      logic [19:0] a;
      logic [15:0] bus_v;
      ncyc = (v.wd && v.addr[0]) ? 2 : 1;
      @(negedge clk);
      req_valid = 1'b1; req_write = v.wr; req_word = v.wd;
      req_addr = v.addr; req_wdata = v.wdata;
      for (int p = 0; p < ncyc; p++) begin
         a = v.addr + 20'(p);
         bus_v = (p == 0) ? v.bus0 : v.bus1;
         // T1
         @(negedge clk);
         chk(addr_strobe && bus_oe, "R2", "T1 strobe/oe", {addr_strobe, bus_oe}, 3);
         chk(bus_ad_o == a, (p == 1) ? "R7" : "R2", "T1 address", bus_ad_o, a);
         chk(hi_lane_n == ((v.wd && !v.addr[0]) ? 1'b0 : !a[0]), "R6", "hi_lane_n",
             32'(hi_lane_n), 32'((v.wd && !v.addr[0]) ? 1'b0 : !a[0]));
         chk(rd_n && wr_n && !req_ack, "R1", "T1 strobes/ack", {rd_n, wr_n, req_ack}, 6);
         ready = 1'b0;  // R9: ignored in T1
         // T2
         @(negedge clk);
         chk(!addr_strobe, "R2", "T2 no strobe", 32'(addr_strobe), 0);
         if (v.wr) begin
            chk(bus_oe && !wr_n && rd_n, "R4", "T2 write pins", {bus_oe, wr_n, rd_n}, 5);
            chk(bus_ad_o[15:0] == exp_lanes(v, p[0]), "R4", "T2 lanes", bus_ad_o, exp_lanes(v, p[0]));
         end else begin
            chk(!bus_oe && rx_dir && !rd_n && wr_n, "R3", "T2 read pins",
                {bus_oe, rx_dir, rd_n, wr_n}, 5);
         end
         ready = 1'b0;  // R9: ignored in T2
         // T3
         @(negedge clk);
         chk(v.wr ? !wr_n : !rd_n, "R1", "T3 strobe", {rd_n, wr_n}, v.wr ? 2 : 1);
         bus_ad_i = bus_v;
         ready = (v.waits == 0);
         for (int k = 0; k < int'(v.waits); k++) begin
            @(negedge clk);
            chk(v.wr ? !wr_n : !rd_n, "R5", "TW strobe held", {rd_n, wr_n}, v.wr ? 2 : 1);
            chk(!req_ack, "R5", "no ack in TW", 32'(req_ack), 0);
            bus_ad_i = ~bus_v;  // garbage until the accepted sample
            if (k == int'(v.waits) - 1) bus_ad_i = bus_v;
            ready = (k == int'(v.waits) - 1);
         end
         // T4
         @(negedge clk);
         ready = 1'b1;
         chk(rd_n && wr_n, v.wr ? "R4" : "R3", "T4 strobes released", {rd_n, wr_n}, 3);
         chk(req_ack == (p == ncyc - 1), (p == 0 && ncyc == 2) ? "R7" : "R1", "T4 ack",
             32'(req_ack), 32'(p == ncyc - 1));
         if (v.wr)
            chk(bus_oe && bus_ad_o[15:0] == exp_lanes(v, p[0]), "R4", "T4 data held",
                bus_ad_o, exp_lanes(v, p[0]));
         else
            chk(!bus_oe && rx_dir, "R3", "T4 bus released", {bus_oe, rx_dir}, 1);
         if (p == ncyc - 1) begin
            if (!v.wr) chk(rsp_rdata == exp_read(v), v.wd ? "R7" : "R6", "read data",
                           rsp_rdata, exp_read(v));
            req_valid = 1'b0;
         end
      end
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R8");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R8");
      for (int i = 0; i < NV; i++) run_txn(VEC[i]);
      repeat (3) begin
         @(negedge clk);
         check_idle("R1");
      end
      // R8: reset in the middle of a write cycle
      req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
      req_addr = 20'h00100; req_wdata = 16'h5A5A;
      @(negedge clk);
      @(negedge clk);
      chk(!wr_n, "R8", "pre-reset T2", 32'(wr_n), 0);
      rst_n = 1'b0;
      #1;
      check_idle("R8");
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R8");
      run_txn(VEC[4]);
      run_txn(VEC[8]);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule